// File: doc/BRIEF.md
# Flash In-System Programming Command Controller

This block lets a processor program an on-chip flash array through a small set of registers. Software first turns on the enable bit and writes a byte address. It then writes a command code and one or two data words. Writing the go bit starts the job. While the program pulse runs, the controller holds the go bit and a busy status bit at 1. When the pulse ends, hardware clears both bits and merges the data into the array.

There are two program commands. One writes a single 32-bit word. The other writes a 64-bit double word, taking the lower word from the low data register and the upper word from the high data register. A 3-bit pulse-time field in the control register makes the busy period longer. Some conditions make a command fail: a disabled controller, an unknown command code, a badly aligned address or an address past the end of the array. A failed command leaves the array untouched and sets a sticky failure flag, which software clears by writing 1 to it.

The array is a synthesizable model of erased flash. It resets to all ones, and programming can only turn bits from 1 to 0. A separate read port returns any array word combinationally, so callers can inspect the array.

Top module: `flash_isp_ctrl`

## Requirements
- R1: After reset the control, go and busy bits read 0 and every array word reads 0xFFFFFFFF. Register select codes: 0 control, 1 address, 2 command, 3 low data, 4 high data, 5 trigger (go = bit 0), 6 status (busy = bit 0).
- R2: Command 0x21 with a 4-byte-aligned in-range address programs the low data register into array word address/4.
- R3: Command 0x61 needs an 8-byte-aligned address. It programs the low data register into word address/4 and the high data register into the word after it.
- R4: Once a valid go is accepted, the go bit and the busy bit both read 1 until the operation completes. Both then read 0 in the same cycle that the array update becomes visible.
- R5: Busy stays high for exactly BASE_CYC + T*STEP_CYC clock cycles, where T is control bits 10:8. With the defaults (4 and 2) this gives 4 cycles for T=0 and 18 cycles for T=7.
- R6: Writing go while the enable bit (control bit 0) is 0 sets the failure flag (control bit 6), does not raise busy and leaves the array unchanged.
- R7: Writing go with any command code other than 0x21 or 0x61 sets the failure flag and leaves the array unchanged.
- R8: A misaligned address, or an address at or beyond DEPTH*4 bytes, makes go set the failure flag and leaves the array unchanged.
- R9: Writing the control register with bit 6 at 1 clears the failure flag. Writing it with bit 6 at 0 leaves the flag as it was.
- R10: While busy is high, writes to the address, command and both data registers are ignored. Their read-back values and the running operation stay unchanged.
- R11: Programming stores the bitwise AND of the new data with the old word, so a bit that is already 0 stays 0.
- R12: A go write while busy is high is ignored. It does not restart or lengthen the operation and does not set the failure flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register select code |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data of the selected register |
| arr_rd_idx | input | IDX_W | Word index for the array read port |
| arr_rd_data | output | 32 | Array word at arr_rd_idx |

## Verification
The bound checker tests on every cycle that:
- the go bit tracks the timer's busy state;
- array writes happen only while busy;
- a pulse never starts without enable, and a failure never coincides with a start;
- busy lasts between the base and maximum lengths;
- the address and data registers hold still during an operation.

Only the bench scenarios can show the exact busy length for each field value, the contents of the array after a run of 32-bit, 64-bit and overlapping programs, and the failure cases at the edge of the array. They also cover register writes ignored mid-operation and the write-1-to-clear flag.

// File: rtl/flash_isp_pkg.sv
package flash_isp_pkg;

    typedef enum logic [2:0] {
        RS_CTRL = 3'd0,
        RS_ADDR = 3'd1,
        RS_CMD  = 3'd2,
        RS_DLO  = 3'd3,
        RS_DHI  = 3'd4,
        RS_TRIG = 3'd5,
        RS_STAT = 3'd6
    } reg_sel_e;

    localparam logic [7:0] OP_PGM_W32 = 8'h21;
    localparam logic [7:0] OP_PGM_W64 = 8'h61;

    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_FAIL_BIT = 6;
    localparam int CTL_PT_LSB   = 8;
    localparam int PT_W         = 3;

    typedef struct packed {
        logic            en;
        logic            fail;
        logic [PT_W-1:0] ptime;
        logic [31:0]     addr;
        logic [7:0]      cmd;
        logic [31:0]     dlo;
        logic [31:0]     dhi;
        logic            go;
        logic            wide;
    } isp_regs_t;

endpackage

// File: rtl/isp_cmd_check.sv
module isp_cmd_check #(
    parameter int DEPTH = 64,
    parameter int IDX_W = 6
) (
    input  logic [7:0]       cmd,
    input  logic [31:0]      addr,
    output logic             cmd_ok,
    output logic             wide,
    output logic [IDX_W-1:0] word_idx
);
    import flash_isp_pkg::*;

    localparam logic [31:0] BYTE_LIMIT = 32'(DEPTH * 4);

    logic known;
    logic aligned;
    logic in_range;

    always_comb begin
        known    = (cmd == OP_PGM_W32) || (cmd == OP_PGM_W64);
        wide     = (cmd == OP_PGM_W64);
        aligned  = wide ? (addr[2:0] == 3'b000) : (addr[1:0] == 2'b00);
        in_range = addr < BYTE_LIMIT;
        cmd_ok   = known && aligned && in_range;
        word_idx = addr[IDX_W+1:2];
    end

endmodule

// File: rtl/isp_pulse_timer.sv
module isp_pulse_timer #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    output logic             busy,
    output logic             done
);
    typedef struct packed {
        logic             busy;
        logic [LEN_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d  = t_q;
        done = 1'b0;
        if (t_q.busy) begin
            if (t_q.cnt == '0) begin
                done     = 1'b1;
                t_d.busy = 1'b0;
            end else begin
                t_d.cnt = t_q.cnt - 1'b1;
            end
        end else if (start) begin
            t_d.busy = 1'b1;
            t_d.cnt  = len - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign busy = t_q.busy;

endmodule

// File: rtl/isp_flash_array.sv
module isp_flash_array #(
    parameter int DEPTH = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pgm_en,
    input  logic             pgm_wide,
    input  logic [IDX_W-1:0] pgm_idx,
    input  logic [31:0]      pgm_lo,
    input  logic [31:0]      pgm_hi,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_data
);
    logic [31:0] mem_d [DEPTH];
    logic [31:0] mem_q [DEPTH];
    logic [IDX_W-1:0] hi_idx;

    assign hi_idx = pgm_idx | IDX_W'(1);

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (pgm_en && (pgm_idx == IDX_W'(i)))
                mem_d[i] = mem_d[i] & pgm_lo;
            if (pgm_en && pgm_wide && (hi_idx == IDX_W'(i)))
                mem_d[i] = mem_d[i] & pgm_hi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rd_data = (32'(rd_idx) < 32'(DEPTH)) ? mem_q[rd_idx] : '1;

endmodule

// File: rtl/flash_isp_ctrl.sv
module flash_isp_ctrl #(
    parameter int DEPTH    = 64,
    parameter int BASE_CYC = 4,
    parameter int STEP_CYC = 2,
    parameter int IDX_W    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [2:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [IDX_W-1:0] arr_rd_idx,
    output logic [31:0]      arr_rd_data
);
    import flash_isp_pkg::*;

    localparam int MAX_LEN = BASE_CYC + ((1 << PT_W) - 1) * STEP_CYC;
    localparam int LEN_W   = $clog2(MAX_LEN + 1);

    isp_regs_t r_d, r_q;

    logic             chk_ok;
    logic             chk_wide;
    logic [IDX_W-1:0] chk_idx;
    logic             tmr_busy;
    logic             tmr_done;
    logic             tmr_start;
    logic [LEN_W-1:0] pulse_len;
    logic             go_accept;

    isp_cmd_check #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_check (
        .cmd      (r_q.cmd),
        .addr     (r_q.addr),
        .cmd_ok   (chk_ok),
        .wide     (chk_wide),
        .word_idx (chk_idx)
    );

    isp_pulse_timer #(.LEN_W(LEN_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .len   (pulse_len),
        .busy  (tmr_busy),
        .done  (tmr_done)
    );

    isp_flash_array #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .pgm_en   (tmr_done),
        .pgm_wide (r_q.wide),
        .pgm_idx  (chk_idx),
        .pgm_lo   (r_q.dlo),
        .pgm_hi   (r_q.dhi),
        .rd_idx   (arr_rd_idx),
        .rd_data  (arr_rd_data)
    );

    assign pulse_len = LEN_W'(BASE_CYC) + LEN_W'(r_q.ptime) * LEN_W'(STEP_CYC);

    always_comb begin
        r_d       = r_q;
        tmr_start = 1'b0;
        go_accept = bus_wr && (bus_addr == RS_TRIG) && bus_wdata[0] && !tmr_busy;

        if (bus_wr && (bus_addr == RS_CTRL)) begin
            r_d.en    = bus_wdata[CTL_EN_BIT];
            r_d.ptime = bus_wdata[CTL_PT_LSB +: PT_W];
            if (bus_wdata[CTL_FAIL_BIT]) r_d.fail = 1'b0;
        end

        if (bus_wr && !tmr_busy) begin
            case (bus_addr)
                RS_ADDR: r_d.addr = bus_wdata;
                RS_CMD:  r_d.cmd  = bus_wdata[7:0];
                RS_DLO:  r_d.dlo  = bus_wdata;
                RS_DHI:  r_d.dhi  = bus_wdata;
                default: ;
            endcase
        end

        if (go_accept) begin
            if (r_q.en && chk_ok) begin
                tmr_start = 1'b1;
                r_d.go    = 1'b1;
                r_d.wide  = chk_wide;
            end else begin
                r_d.fail = 1'b1;
            end
        end

        if (tmr_done) r_d.go = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RS_CTRL: begin
                bus_rdata[CTL_EN_BIT]             = r_q.en;
                bus_rdata[CTL_FAIL_BIT]           = r_q.fail;
                bus_rdata[CTL_PT_LSB +: PT_W]     = r_q.ptime;
            end
            RS_ADDR: bus_rdata = r_q.addr;
            RS_CMD:  bus_rdata = {24'h0, r_q.cmd};
            RS_DLO:  bus_rdata = r_q.dlo;
            RS_DHI:  bus_rdata = r_q.dhi;
            RS_TRIG: bus_rdata = {31'h0, r_q.go};
            RS_STAT: bus_rdata = {31'h0, tmr_busy};
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/flash_isp_ctrl_chk.sv
module flash_isp_ctrl_chk #(
    parameter int BASE_CYC = 4,
    parameter int MAX_LEN  = 18
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        go,
    input logic        en,
    input logic        fail,
    input logic        pgm_en,
    input logic [31:0] addr,
    input logic [31:0] dlo
);
    int unsigned run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_cnt <= 0;
        else if (busy) run_cnt <= run_cnt + 1;
        else           run_cnt <= 0;
    end

    a_r4_go_tracks_busy: assert property (@(posedge clk) disable iff (!rst_n)
        go == busy);

    a_r2_program_inside_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_en |-> busy);

    a_r6_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(en));

    a_r8_fail_never_starts: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> !$rose(busy));

    a_r5_busy_upper_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= MAX_LEN);

    a_r5_busy_lower_bound: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_cnt >= BASE_CYC));

    a_r10_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> $stable(addr));

    a_r10_data_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> $stable(dlo));

endmodule

bind flash_isp_ctrl flash_isp_ctrl_chk #(
    .BASE_CYC (BASE_CYC),
    .MAX_LEN  (MAX_LEN)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (tmr_busy),
    .go     (r_q.go),
    .en     (r_q.en),
    .fail   (r_q.fail),
    .pgm_en (tmr_done),
    .addr   (r_q.addr),
    .dlo    (r_q.dlo)
);

// File: tb/sim_flash_isp_ctrl.sv
`timescale 1ns/1ps
module sim_flash_isp_ctrl;

    localparam int DEPTH = 64;
    localparam int IDX_W = 6;
    localparam int BASE  = 4;
    localparam int STEP  = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_wr = 1'b0;
    logic [2:0]       bus_addr = 3'd0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic [IDX_W-1:0] arr_rd_idx = '0;
    logic [31:0]      arr_rd_data;

    flash_isp_ctrl #(.DEPTH(DEPTH), .BASE_CYC(BASE), .STEP_CYC(STEP)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .arr_rd_idx(arr_rd_idx), .arr_rd_data(arr_rd_data)
    );

    always #4 clk = ~clk;

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;
    int unsigned go_cyc;
    logic [31:0] mdl [DEPTH];

    typedef struct packed {
        logic [7:0]  cmd;
        logic [31:0] addr;
        logic [31:0] lo;
        logic [31:0] hi;
        logic [2:0]  pt;
        logic        bad;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{8'h21, 32'h10,  32'hFFFF_00FF, 32'h0,         3'd0, 1'b0},
        '{8'h61, 32'h20,  32'h1234_5678, 32'h9ABC_DEF0, 3'd3, 1'b0},
        '{8'h21, 32'h10,  32'h0F0F_FFFF, 32'h0,         3'd1, 1'b0},
        '{8'h61, 32'h24,  32'h0,         32'h0,         3'd0, 1'b1},
        '{8'h21, 32'h102, 32'h0,         32'h0,         3'd0, 1'b1},
        '{8'h21, 32'h100, 32'h0,         32'h0,         3'd0, 1'b1},
        '{8'h33, 32'h30,  32'h0,         32'h0,         3'd0, 1'b1},
        '{8'h61, 32'hF8,  32'hF0F0_F0F0, 32'h5555_AAAA, 3'd7, 1'b0},
        '{8'h21, 32'hFC,  32'h0000_FFFF, 32'h0,         3'd2, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
        go_cyc = cyc;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic arr(input int idx, output logic [31:0] d);
        arr_rd_idx = IDX_W'(idx);
        #1 d = arr_rd_data;
    endtask

    task automatic wait_idle(output int unsigned len);
        logic [31:0] s;
        int guard = 0;
        s = 32'h1;
        while (s[0] && guard < 200) begin
            rd(3'd6, s);
            guard++;
        end
        len = cyc - go_cyc;
    endtask

    task automatic cmp_array(input string req);
        logic [31:0] v;
        int bad = 0;
        for (int i = 0; i < DEPTH; i++) begin
            arr(i, v);
            if (v !== mdl[i] && bad == 0) begin
                bad = 1;
                nerr++;
                $display("FAIL %s: word %0d got %h expected %h", req, i, v, mdl[i]);
            end
        end
        nchk++;
    endtask

    initial begin
        #800000;
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int unsigned len;
        for (int i = 0; i < DEPTH; i++) mdl[i] = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, v); chk("R1 ctrl", v, 32'h0);
        rd(3'd5, v); chk("R1 go", v, 32'h0);
        rd(3'd6, v); chk("R1 busy", v, 32'h0);
        cmp_array("R1 erased array");

        // R6 go with enable low
        wr(3'd1, 32'h0); wr(3'd2, 32'h21); wr(3'd3, 32'h0);
        wr(3'd5, 32'h1);
        rd(3'd6, v); chk("R6 no busy", v, 32'h0);
        rd(3'd0, v); chk("R6 fail set", v[6], 32'h1);
        cmp_array("R6 array unchanged");

        // R9 write-1-to-clear
        wr(3'd0, 32'h1);
        rd(3'd0, v); chk("R9 zero keeps flag", v[6], 32'h1);
        wr(3'd0, 32'h41);
        rd(3'd0, v); chk("R9 one clears flag", v[6], 32'h0);

        // Vector table: R2 R3 R5 R7 R8 R11 R4
        for (int k = 0; k < NV; k++) begin
            wr(3'd0, 32'h1 | (32'(VECS[k].pt) << 8));
            wr(3'd1, VECS[k].addr);
            wr(3'd2, {24'h0, VECS[k].cmd});
            wr(3'd3, VECS[k].lo);
            wr(3'd4, VECS[k].hi);
            wr(3'd5, 32'h1);
            if (VECS[k].bad) begin
                rd(3'd6, v); chk($sformatf("R8 R7 vec%0d no busy", k), v, 32'h0);
                rd(3'd0, v); chk($sformatf("R8 R7 vec%0d fail", k), v[6], 32'h1);
                wr(3'd0, 32'h41);
            end else begin
                rd(3'd5, v); chk($sformatf("R4 vec%0d go high", k), v, 32'h1);
                wait_idle(len);
                chk($sformatf("R5 vec%0d busy length", k), len,
                    32'(BASE + VECS[k].pt * STEP));
                rd(3'd5, v); chk($sformatf("R4 vec%0d go cleared", k), v, 32'h0);
                rd(3'd0, v); chk($sformatf("R2 vec%0d no fail", k), v[6], 32'h0);
                mdl[VECS[k].addr[7:2]] &= VECS[k].lo;
                if (VECS[k].cmd == 8'h61) mdl[VECS[k].addr[7:2] + 1] &= VECS[k].hi;
            end
            cmp_array($sformatf("R2 R3 R11 vec%0d array", k));
        end

        // R10 and R12: writes during busy are ignored
        wr(3'd0, 32'h701);
        wr(3'd1, 32'h40); wr(3'd2, 32'h21); wr(3'd3, 32'hAAAA_5555);
        wr(3'd5, 32'h1);
        begin
            int unsigned start_cyc;
            start_cyc = go_cyc;
            wr(3'd1, 32'h44);
            wr(3'd3, 32'h0);
            wr(3'd2, 32'h61);
            wr(3'd5, 32'h1);
            rd(3'd1, v); chk("R10 addr held", v, 32'h40);
            rd(3'd3, v); chk("R10 data held", v, 32'hAAAA_5555);
            go_cyc = start_cyc;
            wait_idle(len);
            chk("R12 length not restarted", len, 32'(BASE + 7 * STEP));
        end
        rd(3'd0, v); chk("R12 no fail", v[6], 32'h0);
        mdl[16] &= 32'hAAAA_5555;
        cmp_array("R10 original op only");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule